// File: doc/BRIEF.md
# Game Controller Condition Responder

This block sits between an input source that reports button presses and a command-list engine that polls a game controller. Each button event arrives as a 16-bit mask of pressed buttons and is queued in a FIFO. When the engine asks for the controller condition of a port, the block takes one entry from the queue. If the queue is empty, it uses an all-released mask instead. It then streams a four-word reply, which the engine writes into its receive buffer.

The reply is a header built from the port number, then the controller function code, then two condition words. The button field in the reply is active-low, so a pressed button reads as 0. The triggers and both analog sticks report zero.

Event input never back-pressures. A push that finds the queue already full is dropped and raises a sticky overrun flag. Requests use a valid/ready handshake, and a new request is accepted only when no reply is in flight. The reply stream holds `rep_data` and `rep_last` steady while `rep_valid` is high and `rep_ready` is low.

Top module: `pad_cond_reply`

## Requirements
- R1: After reset, `rep_valid` and `overrun` are low, `req_ready` is high, and the queue is empty.
- R2: `ev_ready` is always high. Accepted events are returned oldest first, and each accepted request removes exactly one queued event.
- R3: A request that finds the queue empty reports all buttons released: word 2 bits 15:0 read 0xFFFF.
- R4: Word 0 (the header) is {RESP_CODE in bits 31:24, {port,6'b100000} in bits 23:16, {port,6'b000000} in bits 15:8, 8'd3 in bits 7:0}. The default RESP_CODE is 0x08.
- R5: Word 1 equals the parameter FUNC_CODE (default 0x0100_0000).
- R6: Word 2 bits 15:0 hold the bitwise inverse of the popped mask. Bits 7:0 are the low byte and cover C=bit0, B=bit1, A=bit2, Start=bit3, Up=bit4, Down=bit5, Left=bit6, Right=bit7. Bits 15:8 cover Z=bit8, Y=bit9, X=bit10. Word 2 bits 31:16 (the triggers) and all of word 3 (the sticks) are 0.
- R7: The four words leave in order, one per handshake. `rep_last` is high only with the fourth word. While `rep_valid` is high and `rep_ready` is low, the data and last outputs stay unchanged.
- R8: `req_ready` is low from the cycle after a request is accepted until the fourth word's handshake. A request is accepted only when `req_valid` and `req_ready` are both high.
- R9: A push that arrives while the queue holds DEPTH entries, with no pop in the same cycle, is dropped. It sets `overrun`, and the queued contents are unchanged.
- R10: `overrun` stays high until `ovf_clr` is pulsed. If a new overrun and `ovf_clr` occur in the same cycle, the flag stays set.
- R11: A push and a request in the same cycle on an empty queue produce an all-released reply, and the pushed event stays queued for the next request.
- R12: A push and a request in the same cycle on a full queue raise no overrun. The oldest entry is returned and the new event is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_clr | input | 1 | Clears the sticky overrun flag |
| ev_valid | input | 1 | Button event present |
| ev_ready | output | 1 | Always high; events are never back-pressured |
| ev_buttons | input | 16 | Pressed-button mask, active-high |
| req_valid | input | 1 | Get-condition request present |
| req_ready | output | 1 | Request can be accepted |
| req_port | input | 2 | Port number of the request |
| rep_valid | output | 1 | Reply word valid |
| rep_ready | input | 1 | Consumer takes the reply word |
| rep_data | output | 32 | Reply word |
| rep_last | output | 1 | Marks the fourth reply word |
| overrun | output | 1 | Sticky queue overrun flag |

## Verification
The assertions assume that reset is low during the first cycles and that the input source holds `req_port` steady only for the accept cycle, since the block latches it there. The hold check on the reply assumes that the consumer may stall `rep_ready` freely. The bench therefore drives all inputs on the falling edge, keeps `req_valid` low during reset, and alternates `rep_ready` in stalled tests so that the reply is seen both with and without back-pressure. The overrun checks fill the queue to its exact depth before pushing once more, with and without a simultaneous pop.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int BTN_W   = 16;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 4;
  localparam int IDX_W   = $clog2(N_WORDS);

  typedef logic [IDX_W-1:0] word_idx_t;
  localparam word_idx_t LAST_IDX = word_idx_t'(N_WORDS - 1);

  function automatic logic [WORD_W-1:0] make_header(input logic [7:0] code,
                                                    input logic [1:0] port);
    return {code, port, 6'b100000, port, 6'b000000, 8'(N_WORDS - 1)};
  endfunction
endpackage

// File: rtl/pad_event_fifo.sv
module pad_event_fifo
  import pad_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_clr,
  input  logic             push,
  input  logic [BTN_W-1:0] push_data,
  input  logic             pop,
  output logic [BTN_W-1:0] pop_data,
  output logic             overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [BTN_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             ovf_q;

  logic is_empty, is_full, do_push, do_pop, ovf_set;
  assign is_empty = (count == '0);
  assign is_full  = (count == CNT_MAX);
  assign do_pop   = pop && !is_empty;
  assign do_push  = push && (!is_full || do_pop);
  assign ovf_set  = push && is_full && !do_pop;

  assign pop_data = is_empty ? '0 : mem[rd_ptr];
  assign overrun  = ovf_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  // R9: occupancy never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);
  // R9: a rejected push raises the flag
  a_r9_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push && is_full && !pop) |=> overrun);
  // R10: the flag is sticky until cleared
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovf_clr) |=> overrun);
  // R3: an empty queue yields a zero mask
  a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty |-> (pop_data == '0));
endmodule

// File: rtl/pad_reply_seq.sv
module pad_reply_seq
  import pad_pkg::*;
#(
  parameter logic [7:0]        RESP_CODE = 8'h08,
  parameter logic [WORD_W-1:0] FUNC_CODE = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        port,
  input  logic [BTN_W-1:0]  mask,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  logic             busy_q;
  word_idx_t        idx;
  logic [1:0]       port_q;
  logic [BTN_W-1:0] inv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx    <= '0;
      port_q <= '0;
      inv_q  <= '1;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx    <= '0;
        port_q <= port;
        inv_q  <= ~mask;
      end
    end else if (out_ready) begin
      if (idx == LAST_IDX) busy_q <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    case (idx)
      2'd0:    out_data = make_header(RESP_CODE, port_q);
      2'd1:    out_data = FUNC_CODE;
      2'd2:    out_data = {16'h0000, inv_q};
      default: out_data = '0;
    endcase
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_last  = busy_q && (idx == LAST_IDX);

  // R7: a stalled word stays put
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R7: last marks the end, after which the stream stops
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
  // R7: the first word is never the last
  a_r7_first_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (out_valid && !out_last));
endmodule

// File: rtl/pad_cond_reply.sv
module pad_cond_reply
  import pad_pkg::*;
#(
  parameter int                DEPTH     = 4,
  parameter logic [7:0]        RESP_CODE = 8'h08,
  parameter logic [WORD_W-1:0] FUNC_CODE = 32'h0100_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ovf_clr,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [15:0] ev_buttons,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_port,
  output logic        rep_valid,
  input  logic        rep_ready,
  output logic [31:0] rep_data,
  output logic        rep_last,
  output logic        overrun
);
  logic             accept, busy;
  logic [BTN_W-1:0] popped;

  assign ev_ready  = 1'b1;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  pad_event_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_clr   (ovf_clr),
    .push      (ev_valid),
    .push_data (ev_buttons),
    .pop       (accept),
    .pop_data  (popped),
    .overrun   (overrun)
  );

  pad_reply_seq #(.RESP_CODE(RESP_CODE), .FUNC_CODE(FUNC_CODE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .port      (req_port),
    .mask      (popped),
    .busy      (busy),
    .out_valid (rep_valid),
    .out_ready (rep_ready),
    .out_data  (rep_data),
    .out_last  (rep_last)
  );

  // R4: the word after an accept is a header with length 3 and the response code
  a_r4_header: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rep_valid && rep_data[7:0] == 8'd3 && rep_data[31:24] == RESP_CODE));
  // R8: no request is taken while a reply is being emitted
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !(rep_ready && rep_last)) |=> !req_ready);
  // R2: the event input never pushes back
  a_r2_ev_ready: assert property (@(posedge clk) disable iff (!rst_n) ev_ready);
endmodule

// File: tb/sim_pad_cond_reply.sv
module sim_pad_cond_reply;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovf_clr = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [15:0] ev_buttons = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_port = '0;
  logic        rep_valid;
  logic        rep_ready = 1'b0;
  logic [31:0] rep_data;
  logic        rep_last;
  logic        overrun;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] w [4];
  logic        l [4];

  always #2 clk = ~clk;

  pad_cond_reply u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [1:0] p);
    return {8'h08, p, 6'h20, p, 6'h00, 8'd3};
  endfunction

  task automatic push(input logic [15:0] m);
    @(negedge clk); ev_valid = 1'b1; ev_buttons = m;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  // Collect a reply; the request is raised at the current negedge.
  task automatic collect(input logic [1:0] p, input bit stall, input bit with_push,
                         input logic [15:0] pm);
    int n = 0;
    int cyc = 0;
    logic [31:0] prev_d = '0;
    bit prev_stall = 1'b0;
    req_valid = 1'b1; req_port = p;
    if (with_push) begin ev_valid = 1'b1; ev_buttons = pm; end
    @(negedge clk);
    req_valid = 1'b0; ev_valid = 1'b0;
    while (n < 4 && cyc < 40) begin
      if (prev_stall) check("R7 hold", rep_data, prev_d);
      rep_ready = stall ? cyc[0] : 1'b1;
      check("R8 busy", {31'd0, req_ready}, 32'd0);
      prev_stall = rep_valid && !rep_ready;
      prev_d = rep_data;
      if (rep_valid && rep_ready) begin w[n] = rep_data; l[n] = rep_last; n++; end
      @(negedge clk);
      cyc++;
    end
    rep_ready = 1'b0;
    check("R8 ready after", {31'd0, req_ready}, 32'd1);
    check("R7 idle", {31'd0, rep_valid}, 32'd0);
  endtask

  task automatic expect_reply(input string tag, input logic [1:0] p, input logic [15:0] m);
    check({tag, " R4 header"}, w[0], hdr(p));
    check({tag, " R5 func"}, w[1], 32'h0100_0000);
    check({tag, " R6 cond"}, w[2], {16'h0, ~m});
    check({tag, " R6 sticks"}, w[3], 32'h0);
    check({tag, " R7 last"}, {28'd0, l[0], l[1], l[2], l[3]}, 32'h1);
  endtask

  task automatic t_reset;
    check("R1 rep_valid", {31'd0, rep_valid}, 32'd0);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 overrun", {31'd0, overrun}, 32'd0);
    check("R2 ev_ready", {31'd0, ev_ready}, 32'd1);
    @(negedge clk); collect(2'd0, 1'b0, 1'b0, 16'h0);
    expect_reply("R1 empty", 2'd0, 16'h0000);
  endtask

  task automatic t_empty;
    @(negedge clk); collect(2'd3, 1'b1, 1'b0, 16'h0);
    expect_reply("R3", 2'd3, 16'h0000);
  endtask

  task automatic t_order;
    push(16'h0004); push(16'h0401); push(16'h00F0);
    @(negedge clk); collect(2'd1, 1'b0, 1'b0, 16'h0); expect_reply("R2 a", 2'd1, 16'h0004);
    @(negedge clk); collect(2'd2, 1'b1, 1'b0, 16'h0); expect_reply("R2 b", 2'd2, 16'h0401);
    @(negedge clk); collect(2'd0, 1'b0, 1'b0, 16'h0); expect_reply("R6 dir", 2'd0, 16'h00F0);
    @(negedge clk); collect(2'd0, 1'b0, 1'b0, 16'h0); expect_reply("R3 drained", 2'd0, 16'h0000);
  endtask

  task automatic t_overrun;
    push(16'h0001); push(16'h0002); push(16'h0004); push(16'h0008);
    check("R9 no ovf at full", {31'd0, overrun}, 32'd0);
    push(16'h0700);
    check("R9 ovf set", {31'd0, overrun}, 32'd1);
    @(negedge clk); collect(2'd1, 1'b0, 1'b0, 16'h0); expect_reply("R10 kept1", 2'd1, 16'h0001);
    check("R10 sticky", {31'd0, overrun}, 32'd1);
    @(negedge clk); collect(2'd1, 1'b0, 1'b0, 16'h0); expect_reply("R9 k2", 2'd1, 16'h0002);
    @(negedge clk); collect(2'd1, 1'b0, 1'b0, 16'h0); expect_reply("R9 k3", 2'd1, 16'h0004);
    @(negedge clk); collect(2'd1, 1'b0, 1'b0, 16'h0); expect_reply("R9 k4", 2'd1, 16'h0008);
    @(negedge clk); collect(2'd1, 1'b0, 1'b0, 16'h0); expect_reply("R9 dropped", 2'd1, 16'h0000);
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R10 cleared", {31'd0, overrun}, 32'd0);
  endtask

  task automatic t_simul_empty;
    @(negedge clk); collect(2'd2, 1'b0, 1'b1, 16'h0020);
    expect_reply("R11 released", 2'd2, 16'h0000);
    @(negedge clk); collect(2'd2, 1'b0, 1'b0, 16'h0); expect_reply("R11 kept", 2'd2, 16'h0020);
  endtask

  task automatic t_simul_full;
    push(16'h0011); push(16'h0022); push(16'h0044); push(16'h0088);
    @(negedge clk); collect(2'd3, 1'b0, 1'b1, 16'h0300);
    expect_reply("R12 oldest", 2'd3, 16'h0011);
    check("R12 no ovf", {31'd0, overrun}, 32'd0);
    @(negedge clk); collect(2'd3, 1'b0, 1'b0, 16'h0); expect_reply("R12 b", 2'd3, 16'h0022);
    @(negedge clk); collect(2'd3, 1'b0, 1'b0, 16'h0); expect_reply("R12 c", 2'd3, 16'h0044);
    @(negedge clk); collect(2'd3, 1'b0, 1'b0, 16'h0); expect_reply("R12 d", 2'd3, 16'h0088);
    @(negedge clk); collect(2'd3, 1'b0, 1'b0, 16'h0); expect_reply("R12 new", 2'd3, 16'h0300);
  endtask

  task automatic t_ovf_vs_clr;
    push(16'h0001); push(16'h0001); push(16'h0001); push(16'h0001);
    @(negedge clk); ev_valid = 1'b1; ev_buttons = 16'h0002; ovf_clr = 1'b1;
    @(negedge clk); ev_valid = 1'b0; ovf_clr = 1'b0;
    check("R10 set wins", {31'd0, overrun}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_order();
    t_overrun();
    t_simul_empty();
    t_simul_full();
    t_ovf_vs_clr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule